// File: doc/BRIEF.md
# IPv4 Forwarding Header Check and Rewrite

This block sits on the fast forwarding path of a router. Every header beat carries a parsed Ethernet frame: the EtherType, both MAC addresses and the 20-byte IPv4 base header. The block runs a fixed, ordered series of checks on the header and returns a two-bit verdict: drop it, hand it to the slow path for a time-exceeded reply, hand it to the slow path for complex handling, or forward it in hardware.

When the verdict is forward, the block rewrites the header. The hop count goes down by one, and the header checksum is patched for that single change instead of being recomputed over all twenty bytes. The Ethernet source address becomes the MAC of the egress port, and the destination address becomes the MAC of the next hop. Both of those addresses come from an external lookup and arrive on input ports alongside the header. For any other verdict the frame fields pass through untouched, so the slow path sees exactly what arrived.

A correctly verified header that reaches the forward verdict depends only on the EtherType, the version/length byte, the fragment fields, the TTL and the destination address. This is what lets a decision cache key on those fields instead of the whole header.

Top module: `ipv4_hdr_rewrite`

## Requirements
- R1: `out_valid` is high for exactly the one cycle that follows each cycle with `in_valid` high, and is low in every other cycle.
- R2: An EtherType other than 16'h0800 gives verdict 2'b01 (drop), whatever the header holds.
- R3: An IPv4 frame whose TTL (header byte 8) is 0 or 1 gives verdict 2'b10 (time-exceeded to slow path), even when its checksum is wrong.
- R4: An IPv4 frame with TTL of 2 or more whose header does not sum to 16'hFFFF gives verdict 2'b01 (drop). The sum is a one's-complement sum of the ten big-endian 16-bit header words.
- R5: An IPv4 frame that passes R2 to R4 and has options (low nibble of byte 0 not equal to 5) or is a fragment gives verdict 2'b11 (complex, to slow path). A fragment has the more-fragments flag set (bit 5 of byte 6) or a nonzero 13-bit offset (low 5 bits of byte 6 with byte 7).
- R6: All other frames give verdict 2'b00 (forward), and the output TTL equals the input TTL minus one.
- R7: On forward, the output header sums to 16'hFFFF under the R4 rule. Only bytes 8, 10 and 11 differ from the input header.
- R8: On forward, `out_src_mac` equals `egress_mac` and `out_dst_mac` equals `nexthop_mac`.
- R9: On any verdict other than forward, `out_hdr`, `out_src_mac` and `out_dst_mac` equal the inputs unchanged.
- R10: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Header present this cycle |
| in_etype | input | 16 | EtherType of the frame |
| in_hdr | input | 160 | IPv4 base header, byte 0 in bits 159:152 |
| in_src_mac | input | 48 | Arriving Ethernet source address |
| in_dst_mac | input | 48 | Arriving Ethernet destination address |
| egress_mac | input | 48 | MAC of the chosen output port |
| nexthop_mac | input | 48 | MAC of the next-hop neighbour |
| out_valid | output | 1 | Verdict and frame fields valid |
| out_verdict | output | 2 | 00 forward, 01 drop, 10 time-exceeded, 11 complex |
| out_hdr | output | 160 | Header, rewritten on forward |
| out_src_mac | output | 48 | Outgoing source address |
| out_dst_mac | output | 48 | Outgoing destination address |

## Verification
A near-exhaustive grid crosses EtherType, TTL from 0 to 3, a good or corrupted checksum, option length and both kinds of fragmentation. Because the grid contains every pair of conflicting conditions, it separates a correct check order from any reordering; for example, a TTL of 1 with a bad checksum tells the R3-before-R4 order apart from the reverse. A sweep of every TTL from 2 to 255 across several protocol values and addresses exercises the carry and wrap cases of the incremental checksum patch, and each result is checked by summing the whole output header. Back-to-back beats and idle cycles check the one-cycle strobe.

// File: rtl/ipv4_rw_pkg.sv
package ipv4_rw_pkg;
  localparam int HDR_BYTES = 20;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int HDR_WORDS = HDR_BYTES / 2;

  // byte positions inside the header vector (byte 0 is most significant)
  localparam int B_VIHL  = 0;
  localparam int B_FLAGS = 6;
  localparam int B_TTL   = 8;
  localparam int B_CSUM  = 10;

  typedef enum logic [1:0] {
    VERD_FWD  = 2'b00,
    VERD_DROP = 2'b01,
    VERD_TTLX = 2'b10,
    VERD_SLOW = 2'b11
  } verdict_e;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] hdr_word(input logic [HDR_W-1:0] h, input int idx);
    return h[HDR_W-1-16*idx -: 16];
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [HDR_W-1:0] h, input int idx);
    return h[HDR_W-1-8*idx -: 8];
  endfunction

  function automatic logic [15:0] hdr_sum(input logic [HDR_W-1:0] h);
    logic [15:0] acc;
    acc = 16'd0;
    for (int i = 0; i < HDR_WORDS; i++) acc = oc_add(acc, hdr_word(h, i));
    return acc;
  endfunction

  // patch checksum hc after 16-bit word old_w becomes new_w
  function automatic logic [15:0] csum_patch(input logic [15:0] hc,
                                             input logic [15:0] old_w,
                                             input logic [15:0] new_w);
    return ~oc_add(oc_add(~hc, ~old_w), new_w);
  endfunction
endpackage

// File: rtl/ipv4_csum_check.sv
module ipv4_csum_check
  import ipv4_rw_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output logic             sum_ok
);
  logic [15:0] words [HDR_WORDS];
  logic [15:0] chain [HDR_WORDS+1];

  assign chain[0] = 16'd0;

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
    assign words[g]   = hdr[HDR_W-1-16*g -: 16];
    assign chain[g+1] = oc_add(chain[g], words[g]);
  end

  assign sum_ok = (chain[HDR_WORDS] == 16'hFFFF);
endmodule

// File: rtl/ipv4_ttl_patch.sv
module ipv4_ttl_patch
  import ipv4_rw_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_out
);
  localparam int TTL_HI  = HDR_W - 1 - 8 * B_TTL;
  localparam int CSUM_HI = HDR_W - 1 - 8 * B_CSUM;

  logic [7:0]  ttl_old, ttl_new, proto;
  logic [15:0] csum_old, csum_new;

  always_comb begin
    ttl_old  = hdr_in[TTL_HI -: 8];
    proto    = hdr_in[TTL_HI-8 -: 8];
    csum_old = hdr_in[CSUM_HI -: 16];
    ttl_new  = ttl_old - 8'd1;
    csum_new = csum_patch(csum_old, {ttl_old, proto}, {ttl_new, proto});
    hdr_out  = hdr_in;
    hdr_out[TTL_HI -: 8]   = ttl_new;
    hdr_out[CSUM_HI -: 16] = csum_new;
  end
endmodule

// File: rtl/ipv4_classify.sv
module ipv4_classify
  import ipv4_rw_pkg::*;
(
  input  logic       is_ipv4,
  input  logic [7:0] ttl,
  input  logic       sum_ok,
  input  logic [3:0] ihl,
  input  logic       more_frags,
  input  logic [12:0] frag_off,
  output logic [1:0] verdict
);
  logic ttl_expired, has_opts, is_frag;

  assign ttl_expired = (ttl <= 8'd1);
  assign has_opts    = (ihl != 4'd5);
  assign is_frag     = more_frags || (frag_off != 13'd0);

  // ordered checks: first match wins
  always_comb begin
    if (!is_ipv4)                verdict = VERD_DROP;
    else if (ttl_expired)        verdict = VERD_TTLX;
    else if (!sum_ok)            verdict = VERD_DROP;
    else if (has_opts || is_frag) verdict = VERD_SLOW;
    else                         verdict = VERD_FWD;
  end
endmodule

// File: rtl/ipv4_hdr_rewrite.sv
module ipv4_hdr_rewrite
  import ipv4_rw_pkg::*;
#(
  parameter int          MAC_W      = 48,
  parameter int          ETYPE_W    = 16,
  parameter logic [15:0] IPV4_ETYPE = 16'h0800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ETYPE_W-1:0] in_etype,
  input  logic [HDR_W-1:0]   in_hdr,
  input  logic [MAC_W-1:0]   in_src_mac,
  input  logic [MAC_W-1:0]   in_dst_mac,
  input  logic [MAC_W-1:0]   egress_mac,
  input  logic [MAC_W-1:0]   nexthop_mac,
  output logic               out_valid,
  output logic [1:0]         out_verdict,
  output logic [HDR_W-1:0]   out_hdr,
  output logic [MAC_W-1:0]   out_src_mac,
  output logic [MAC_W-1:0]   out_dst_mac
);
  localparam int FLAGS_HI = HDR_W - 1 - 8 * B_FLAGS;
  localparam int TTL_HI   = HDR_W - 1 - 8 * B_TTL;
  localparam int IHL_HI   = HDR_W - 1 - 8 * B_VIHL - 4;

  // named internal events
  logic             is_ipv4;
  logic [7:0]       ttl_in;
  logic [3:0]       ihl_in;
  logic             mf_in;
  logic [12:0]      off_in;
  logic             sum_ok;
  logic [1:0]       verdict_c;
  logic             fwd_c;
  logic [HDR_W-1:0] hdr_patched;

  assign is_ipv4 = (in_etype == ETYPE_W'(IPV4_ETYPE));
  assign ttl_in  = in_hdr[TTL_HI -: 8];
  assign ihl_in  = in_hdr[IHL_HI -: 4];
  assign mf_in   = in_hdr[FLAGS_HI-2];
  assign off_in  = in_hdr[FLAGS_HI-3 -: 13];

  ipv4_csum_check u_sum (
    .hdr    (in_hdr),
    .sum_ok (sum_ok)
  );

  ipv4_ttl_patch u_patch (
    .hdr_in  (in_hdr),
    .hdr_out (hdr_patched)
  );

  ipv4_classify u_cls (
    .is_ipv4    (is_ipv4),
    .ttl        (ttl_in),
    .sum_ok     (sum_ok),
    .ihl        (ihl_in),
    .more_frags (mf_in),
    .frag_off   (off_in),
    .verdict    (verdict_c)
  );

  assign fwd_c = (verdict_c == VERD_FWD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_verdict <= VERD_DROP;
      out_hdr     <= '0;
      out_src_mac <= '0;
      out_dst_mac <= '0;
    end else if (in_valid) begin
      out_verdict <= verdict_c;
      out_hdr     <= fwd_c ? hdr_patched : in_hdr;
      out_src_mac <= fwd_c ? egress_mac  : in_src_mac;
      out_dst_mac <= fwd_c ? nexthop_mac : in_dst_mac;
    end
  end

  // R1: strobe follows each input beat by one cycle
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: non-IPv4 frames dropped
  p_etype_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_ipv4) |=> (out_verdict == VERD_DROP));

  // R3: expired TTL wins over checksum
  p_ttl_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ipv4 && ttl_in <= 8'd1) |=> (out_verdict == VERD_TTLX));

  // R4: bad sum with live TTL dropped
  p_badsum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ipv4 && ttl_in > 8'd1 && !sum_ok) |=> (out_verdict == VERD_DROP));

  // R6: forwarded TTL one lower than arriving TTL
  p_fwd_ttl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_verdict == VERD_FWD) |->
      (out_hdr[TTL_HI -: 8] == $past(ttl_in) - 8'd1));

  // R7: patched header still verifies under the full sum
  p_fwd_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_verdict == VERD_FWD) |-> (hdr_sum(out_hdr) == 16'hFFFF));

  // R8: addresses taken from lookup on forward
  p_fwd_mac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_verdict == VERD_FWD) |->
      (out_src_mac == $past(egress_mac) && out_dst_mac == $past(nexthop_mac)));
endmodule

// File: tb/ipv4_hdr_rewrite_test.sv
`timescale 1ns/1ps
module ipv4_hdr_rewrite_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [15:0]  in_etype = '0;
  logic [159:0] in_hdr = '0;
  logic [47:0]  in_src_mac = '0, in_dst_mac = '0, egress_mac = '0, nexthop_mac = '0;
  logic         out_valid;
  logic [1:0]   out_verdict;
  logic [159:0] out_hdr;
  logic [47:0]  out_src_mac, out_dst_mac;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipv4_hdr_rewrite uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_etype(in_etype),
    .in_hdr(in_hdr), .in_src_mac(in_src_mac), .in_dst_mac(in_dst_mac),
    .egress_mac(egress_mac), .nexthop_mac(nexthop_mac),
    .out_valid(out_valid), .out_verdict(out_verdict), .out_hdr(out_hdr),
    .out_src_mac(out_src_mac), .out_dst_mac(out_dst_mac)
  );

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 32-bit accumulate then fold twice
  function automatic logic [15:0] fold_sum(input logic [159:0] h);
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 10; i++) s += h[159-16*i -: 16];
    s = (s & 32'hFFFF) + (s >> 16);
    s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  function automatic logic [159:0] mk_hdr(input logic [3:0] ihl, input logic [15:0] ff,
                                          input logic [7:0] ttl, input logic [7:0] proto,
                                          input logic [31:0] sa, input logic [31:0] da);
    logic [159:0] h;
    h = {4'h4, ihl, 8'h00, 16'd60, 16'h1c46, ff, ttl, proto, 16'h0000, sa, da};
    h[79:64] = ~fold_sum(h);
    return h;
  endfunction

  function automatic logic [1:0] exp_verdict(input logic [15:0] et, input logic [159:0] h);
    if (et != 16'h0800) return 2'b01;
    if (h[95:88] <= 8'd1) return 2'b10;
    if (fold_sum(h) != 16'hFFFF) return 2'b01;
    if (h[155:152] != 4'd5 || h[109] || h[108:96] != 13'd0) return 2'b11;
    return 2'b00;
  endfunction

  task automatic run(input logic [15:0] et, input logic [159:0] h, input string tag);
    logic [1:0]   ev;
    logic [159:0] mask;
    ev = exp_verdict(et, h);
    @(negedge clk);
    in_valid = 1'b1; in_etype = et; in_hdr = h;
    in_src_mac = {16'hA0A0, h[63:32]}; in_dst_mac = {16'hB0B0, h[31:0]};
    egress_mac = {16'h0E0E, h[31:0] ^ 32'h5A5A5A5A}; nexthop_mac = {16'h0F0F, h[63:32] ^ 32'h3C3C3C3C};
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R1 strobe", {159'd0, out_valid}, 160'd1);
    chk(out_verdict === ev, tag, {158'd0, out_verdict}, {158'd0, ev});
    if (ev == 2'b00) begin
      chk(out_hdr[95:88] === h[95:88] - 8'd1, "R6 ttl", {152'd0, out_hdr[95:88]}, {152'd0, h[95:88] - 8'd1});
      chk(fold_sum(out_hdr) === 16'hFFFF, "R7 sum", {144'd0, fold_sum(out_hdr)}, {144'd0, 16'hFFFF});
      mask = {64'hFFFFFFFF_FFFFFFFF, 8'h00, 8'hFF, 16'h0000, 64'hFFFFFFFF_FFFFFFFF};
      chk((out_hdr & mask) === (h & mask), "R7 untouched bytes", out_hdr & mask, h & mask);
      chk(out_src_mac === egress_mac && out_dst_mac === nexthop_mac, "R8 mac",
          {out_src_mac, out_dst_mac}, {egress_mac, nexthop_mac});
    end else begin
      chk(out_hdr === h, "R9 hdr passthrough", out_hdr, h);
      chk(out_src_mac === in_src_mac && out_dst_mac === in_dst_mac, "R9 mac passthrough",
          {out_src_mac, out_dst_mac}, {in_src_mac, in_dst_mac});
    end
  endtask

  initial begin
    repeat (10000000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [159:0] h;
    string        tg;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset", {159'd0, out_valid}, 160'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle after reset", {159'd0, out_valid}, 160'd0);

    // ordering grid: etype x ttl x checksum x options x fragment kind
    for (int e = 0; e < 2; e++)
      for (int t = 0; t < 4; t++)
        for (int b = 0; b < 2; b++)
          for (int o = 0; o < 2; o++)
            for (int f = 0; f < 3; f++) begin
              logic [15:0] ff;
              logic [15:0] et;
              et = e ? 16'h86DD : 16'h0800;
              ff = (f == 0) ? 16'h4000 : (f == 1) ? 16'h2000 : 16'h00B9;
              h = mk_hdr(o ? 4'd6 : 4'd5, ff, 8'(t), 8'd17, 32'h0A000001 + t, 32'hC0A80101 + f);
              if (b) h[79:64] = h[79:64] ^ 16'h0100;
              if (e) tg = "R2 non-ipv4 drop";
              else if (t <= 1) tg = "R3 ttl expired";
              else if (b) tg = "R4 bad sum drop";
              else if (o || f != 0) tg = "R5 complex";
              else tg = "R6 forward";
              run(et, h, tg);
            end

    // forward sweep across every live TTL and several protocols
    for (int t = 2; t < 256; t++)
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pr;
        pr = (p == 0) ? 8'd6 : (p == 1) ? 8'd17 : 8'hFF;
        h = mk_hdr(4'd5, 16'h0000, 8'(t), pr, 32'hFFFF0000 ^ (t * 977), 32'h0000FFFF + (t << 8));
        run(16'h0800, h, "R6 forward sweep");
      end

    // back-to-back beats then idle
    @(negedge clk);
    in_valid = 1'b1; in_etype = 16'h0800; in_hdr = mk_hdr(4'd5, 16'h0, 8'd64, 8'd6, 32'h01020304, 32'h05060708);
    @(negedge clk);
    chk(out_valid === 1'b1, "R1 beat1", {159'd0, out_valid}, 160'd1);
    in_etype = 16'h0806;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && out_verdict === 2'b01, "R1 beat2 / R2", {158'd0, out_valid, out_verdict[0]}, 160'd3);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 idle", {159'd0, out_valid}, 160'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule